// File: doc/BRIEF.md
# DRAM Refresh and Initialization Scheduler

This block decides when an asynchronous DRAM has to see refresh activity and drives the row and column strobes itself while that activity runs. After reset it holds off all traffic for a power-up pause. It then runs a burst of wake-up refreshes before it declares the memory ready. From then on a free-running interval timer queues one CAS-before-RAS refresh per period, which spreads the full row sweep evenly across the retention window.

The block shares the strobes with an access sequencer through a request/grant pair. The scheduler raises `ref_req`, and the sequencer finishes its current access, holds back new ones and answers with `bus_gnt`. The scheduler then owns the strobes for as long as `ref_busy` is high. Refresh periods that expire while the grant is withheld are counted up to a fixed backlog. One more expiry beyond that limit means the retention window may already have been missed. In that case the block pulses `ovf`, drops `init_done` and repeats the whole wake-up burst.

A host can also ask for the low-power retention mode with `sr_req`. The scheduler enters it through a CAS-before-RAS start and keeps RAS low for at least the minimum retention hold, even if the request is withdrawn early. On exit it keeps both strobes high for the exit recovery time before it releases the bus. All timings are parameters in clock cycles, and their defaults are derived from nanosecond values and the clock period.

Top module: `drr_sched`

## Requirements
- R1: After reset, `ref_req` and `ref_busy` stay low, `init_done` stays low and both strobes stay high for the first `PAUSE_CYC` clock cycles.
- R2: After the pause, exactly `WAKE_CNT` refresh cycles run before `init_done` goes high.
- R3: Once `init_done` is high and the grant is always available, successive refresh RAS falling edges are exactly `INTERVAL_CYC` cycles apart.
- R4: The strobes move only after `ref_req` and `bus_gnt` were both high in the same cycle. Whenever `ref_busy` is low, `ras_n` and `cas_n` are both high.
- R5: Each cycle begins with `cas_n` low and `ras_n` high for exactly `T_CSR` cycles, and `ras_n` never falls while `cas_n` is high.
- R6: In a refresh cycle `ras_n` is low for exactly `T_RAS` cycles, `cas_n` stays low for the first `T_CHR` of them, and both strobes are then high for `T_RP` cycles before `ref_busy` falls.
- R7: When a refresh is pending and `sr_req` is also high at grant time, the plain refresh cycle runs first and the retention mode is entered afterwards.
- R8: In retention mode `sr_active` is high and `ras_n` stays low for at least `T_RASS` cycles even if `sr_req` drops earlier. It stays low while `sr_req` is held.
- R9: On leaving retention mode, both strobes are high for exactly `T_RPS` cycles before `ref_busy` falls.
- R10: At most `MAX_PEND` refreshes are held while the grant is withheld. A further period expiry gives a one-cycle `ovf` pulse, clears the backlog, drops `init_done` and re-runs `WAKE_CNT` wake-up cycles.
- R11: After the grant returns, a held backlog of N refreshes is served as N back-to-back cycles, after which `ref_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_gnt | input | 1 | Sequencer hands the strobes to the scheduler |
| sr_req | input | 1 | Request to enter and remain in the retention mode |
| ref_req | output | 1 | Scheduler wants the strobes |
| ref_busy | output | 1 | Scheduler is driving the strobes |
| init_done | output | 1 | Power-up pause and wake-up burst complete, normal access allowed |
| sr_active | output | 1 | Retention mode is being held |
| ovf | output | 1 | One-cycle pulse when the refresh backlog is exceeded |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |

## Verification
The hardest state to reach is the backlog limit. It needs the grant withheld across several whole refresh periods, and the period boundary has to be known from outside. The bench withholds the grant and waits for `ref_req` to rise, which marks the exact cycle a period expired. It then waits a chosen number of periods plus half a period, so the count of expiries is certain. This gives a backlog of one, two or three, and also one and two expiries past the limit. After each wait the bench grants the bus and counts how many refresh cycles drain.

// File: rtl/drr_pkg.sv
package drr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CSR,
    ST_RASLO,
    ST_PRE,
    ST_SRHOLD,
    ST_SREXIT
  } drr_state_e;

  // Round a nanosecond figure up to whole clock cycles.
  function automatic int unsigned ns_to_cyc(int unsigned ns, int unsigned clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  // Round down: a refresh period must never be stretched.
  function automatic int unsigned ns_floor_cyc(int unsigned ns, int unsigned clk_ns);
    return ns / clk_ns;
  endfunction

  function automatic int unsigned umax(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // True on the final cycle of a phase that lasts lim cycles.
  function automatic logic hit_last(int unsigned cnt, int unsigned lim);
    return (cnt + 1 >= lim);
  endfunction

  // Backlog update: one in per period expiry, one out per served refresh.
  function automatic int unsigned pend_next(int unsigned p, logic up, logic dn);
    return p + (up ? 1 : 0) - (dn ? 1 : 0);
  endfunction

endpackage

// File: rtl/drr_timer.sv
module drr_timer #(
  parameter int unsigned PAUSE_CYC    = 20000,
  parameter int unsigned INTERVAL_CYC = 1562
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_en,
  output logic pause_done,
  output logic tick
);
  localparam int unsigned PW = $clog2(PAUSE_CYC + 1);
  localparam int unsigned IW = $clog2(INTERVAL_CYC + 1);

  logic [PW-1:0] p_cnt;
  logic [IW-1:0] i_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_cnt      <= '0;
      pause_done <= 1'b0;
    end else if (!pause_done) begin
      if (drr_pkg::hit_last(32'(p_cnt), PAUSE_CYC)) pause_done <= 1'b1;
      else p_cnt <= p_cnt + PW'(1);
    end
  end

  assign tick = run_en && drr_pkg::hit_last(32'(i_cnt), INTERVAL_CYC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) i_cnt <= '0;
    else if (!run_en || tick) i_cnt <= '0;
    else i_cnt <= i_cnt + IW'(1);
  end

endmodule

// File: rtl/drr_ledger.sv
module drr_ledger #(
  parameter int unsigned WAKE_CNT = 8,
  parameter int unsigned MAX_PEND = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pause_done,
  input  logic tick,
  input  logic cyc_done,
  output logic need,
  output logic init_done,
  output logic ovf
);
  localparam int unsigned WW = $clog2(WAKE_CNT + 1);
  localparam int unsigned QW = $clog2(MAX_PEND + 1);

  logic [WW-1:0] wake_left;
  logic [QW-1:0] pend;
  logic          dec;
  logic          full;

  assign dec       = cyc_done && (wake_left == '0) && (pend != '0);
  assign full      = (32'(pend) == MAX_PEND);
  assign ovf       = tick && full && !dec;
  assign init_done = pause_done && (wake_left == '0);
  assign need      = pause_done && ((wake_left != '0) || (pend != '0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wake_left <= WW'(WAKE_CNT);
      pend      <= '0;
    end else if (ovf) begin
      wake_left <= WW'(WAKE_CNT);
      pend      <= '0;
    end else begin
      if (cyc_done && (wake_left != '0)) wake_left <= wake_left - WW'(1);
      pend <= QW'(drr_pkg::pend_next(32'(pend), tick, dec));
    end
  end

  // R10: backlog never exceeds its limit
  p_pend_cap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    32'(pend) <= MAX_PEND);

  // R10: an overflow withdraws readiness on the next cycle
  p_ovf_rewake_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> !init_done);

  // R2: readiness appears only as a completed refresh cycle retires
  p_ready_after_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_done) |-> $past(cyc_done));

endmodule

// File: rtl/drr_strobe.sv
module drr_strobe #(
  parameter int unsigned T_CSR  = 1,
  parameter int unsigned T_RAS  = 5,
  parameter int unsigned T_CHR  = 1,
  parameter int unsigned T_RP   = 3,
  parameter int unsigned T_RASS = 10000,
  parameter int unsigned T_RPS  = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic need,
  input  logic sr_ok,
  input  logic sr_req,
  input  logic bus_gnt,
  output logic ref_req,
  output logic ref_busy,
  output logic cyc_done,
  output logic sr_active,
  output logic ras_n,
  output logic cas_n
);
  import drr_pkg::*;

  localparam int unsigned CMAX = umax(umax(umax(T_CSR, T_RAS), umax(T_RP, T_RPS)), T_RASS);
  localparam int unsigned CW   = $clog2(CMAX + 1);
  localparam int unsigned LW   = $clog2(T_RASS + 1);

  drr_state_e    state;
  logic [CW-1:0] cnt;
  logic          is_sr;
  logic          start;
  logic          cnt_last;
  logic          cas_hold;
  logic          hold_met;
  int unsigned   lim_now;

  always_comb begin
    case (state)
      ST_CSR:    lim_now = T_CSR;
      ST_RASLO:  lim_now = T_RAS;
      ST_PRE:    lim_now = T_RP;
      ST_SREXIT: lim_now = T_RPS;
      default:   lim_now = 1;
    endcase
  end

  assign cnt_last = hit_last(32'(cnt), lim_now);
  assign cas_hold = (32'(cnt) < T_CHR);
  assign hold_met = (32'(cnt) >= T_RASS);

  assign ref_req   = (state == ST_IDLE) && (need || (sr_ok && sr_req));
  assign start     = ref_req && bus_gnt;
  assign ref_busy  = (state != ST_IDLE);
  assign cyc_done  = (state == ST_PRE) && cnt_last;
  assign sr_active = (state == ST_SRHOLD);
  assign ras_n     = !((state == ST_RASLO) || (state == ST_SRHOLD));
  assign cas_n     = !((state == ST_CSR) ||
                       (((state == ST_RASLO) || (state == ST_SRHOLD)) && cas_hold));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      is_sr <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            state <= ST_CSR;
            cnt   <= '0;
            is_sr <= !need;
          end
        end
        ST_CSR: begin
          if (cnt_last) begin
            state <= is_sr ? ST_SRHOLD : ST_RASLO;
            cnt   <= '0;
          end else cnt <= cnt + CW'(1);
        end
        ST_RASLO: begin
          if (cnt_last) begin
            state <= ST_PRE;
            cnt   <= '0;
          end else cnt <= cnt + CW'(1);
        end
        ST_PRE: begin
          if (cnt_last) begin
            state <= ST_IDLE;
            cnt   <= '0;
          end else cnt <= cnt + CW'(1);
        end
        ST_SRHOLD: begin
          if (hold_met && !sr_req) begin
            state <= ST_SREXIT;
            cnt   <= '0;
          end else if (!hold_met) cnt <= cnt + CW'(1);
        end
        ST_SREXIT: begin
          if (cnt_last) begin
            state <= ST_IDLE;
            cnt   <= '0;
          end else cnt <= cnt + CW'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Checker-side run length of RAS low, independent of the phase counter.
  logic [LW-1:0] lo_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lo_len <= '0;
    else if (ras_n) lo_len <= '0;
    else if (32'(lo_len) < T_RASS) lo_len <= lo_len + LW'(1);
  end

  // R5: RAS only falls after CAS was already low
  p_cas_lead_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> $past(!cas_n));

  // R6: CAS is released before RAS rises
  p_cas_up_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> cas_n);

  // R4: taking the strobes follows a granted request
  p_busy_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ref_busy) |-> $past(ref_req && bus_gnt));

  // R4: strobes rest high when the bus is not owned
  p_idle_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_busy |-> (ras_n && cas_n));

  // R8: a retention hold keeps RAS low for its minimum time
  p_sr_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ras_n) && $past(sr_active)) |-> (32'(lo_len) >= T_RASS));

endmodule

// File: rtl/drr_sched.sv
module drr_sched #(
  parameter int unsigned CLK_NS       = 10,
  parameter int unsigned PAUSE_CYC    = drr_pkg::ns_to_cyc(200_000, CLK_NS),
  parameter int unsigned WAKE_CNT     = 8,
  parameter int unsigned INTERVAL_CYC = drr_pkg::ns_floor_cyc(15_625, CLK_NS),
  parameter int unsigned MAX_PEND     = 4,
  parameter int unsigned T_CSR        = drr_pkg::ns_to_cyc(5, CLK_NS),
  parameter int unsigned T_RAS        = drr_pkg::ns_to_cyc(50, CLK_NS),
  parameter int unsigned T_CHR        = drr_pkg::ns_to_cyc(10, CLK_NS),
  parameter int unsigned T_RP         = drr_pkg::ns_to_cyc(30, CLK_NS),
  parameter int unsigned T_RASS       = drr_pkg::ns_to_cyc(100_000, CLK_NS),
  parameter int unsigned T_RPS        = drr_pkg::ns_to_cyc(84, CLK_NS)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_gnt,
  input  logic sr_req,
  output logic ref_req,
  output logic ref_busy,
  output logic init_done,
  output logic sr_active,
  output logic ovf,
  output logic ras_n,
  output logic cas_n
);
  logic pause_done;
  logic tick;
  logic need;
  logic cyc_done;
  logic run_en;

  assign run_en = init_done && !sr_active;

  drr_timer #(
    .PAUSE_CYC   (PAUSE_CYC),
    .INTERVAL_CYC(INTERVAL_CYC)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_en    (run_en),
    .pause_done(pause_done),
    .tick      (tick)
  );

  drr_ledger #(
    .WAKE_CNT(WAKE_CNT),
    .MAX_PEND(MAX_PEND)
  ) u_ledger (
    .clk       (clk),
    .rst_n     (rst_n),
    .pause_done(pause_done),
    .tick      (tick),
    .cyc_done  (cyc_done),
    .need      (need),
    .init_done (init_done),
    .ovf       (ovf)
  );

  drr_strobe #(
    .T_CSR (T_CSR),
    .T_RAS (T_RAS),
    .T_CHR (T_CHR),
    .T_RP  (T_RP),
    .T_RASS(T_RASS),
    .T_RPS (T_RPS)
  ) u_strobe (
    .clk      (clk),
    .rst_n    (rst_n),
    .need     (need),
    .sr_ok    (init_done),
    .sr_req   (sr_req),
    .bus_gnt  (bus_gnt),
    .ref_req  (ref_req),
    .ref_busy (ref_busy),
    .cyc_done (cyc_done),
    .sr_active(sr_active),
    .ras_n    (ras_n),
    .cas_n    (cas_n)
  );

  // R1: nothing is requested or driven during the power-up pause
  p_quiet_pause_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !pause_done |-> (!ref_req && !ref_busy && !init_done));

endmodule

// File: tb/test_drr_sched.sv
module test_drr_sched;
  localparam int CLK_PERIOD = 10;
  localparam int PAUSE = 20;
  localparam int WAKE  = 8;
  localparam int INTV  = 80;
  localparam int MAXP  = 3;
  localparam int TCSR  = 2;
  localparam int TRAS  = 4;
  localparam int TCHR  = 2;
  localparam int TRP   = 3;
  localparam int TRASS = 30;
  localparam int TRPS  = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_gnt = 1'b0;
  logic sr_req = 1'b0;
  logic ref_req, ref_busy, init_done, sr_active, ovf, ras_n, cas_n;

  always #(CLK_PERIOD/2) clk = ~clk;

  drr_sched #(
    .CLK_NS(10), .PAUSE_CYC(PAUSE), .WAKE_CNT(WAKE), .INTERVAL_CYC(INTV),
    .MAX_PEND(MAXP), .T_CSR(TCSR), .T_RAS(TRAS), .T_CHR(TCHR), .T_RP(TRP),
    .T_RASS(TRASS), .T_RPS(TRPS)
  ) i_drr_sched (
    .clk(clk), .rst_n(rst_n), .bus_gnt(bus_gnt), .sr_req(sr_req),
    .ref_req(ref_req), .ref_busy(ref_busy), .init_done(init_done),
    .sr_active(sr_active), .ovf(ovf), .ras_n(ras_n), .cas_n(cas_n)
  );

  // Grant-withholding scenarios: periods held past the first expiry,
  // refresh cycles expected to drain, overflow pulses expected.
  typedef struct packed { int m; int drain; int novf; } vec_t;
  localparam vec_t VECS [5] = '{
    '{0, 1, 0}, '{1, 2, 0}, '{2, 3, 0}, '{3, WAKE, 1}, '{4, WAKE, 1}
  };

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000 && !done) begin
      checks = checks + 1;
      errors = errors + 1;
      $display("FAIL all requirements: watchdog expired, actual %0d cycles expected fewer", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Wait for the scheduler to take the bus, then profile the strobes.
  task automatic busy_period(output int n_csr, output int n_lo, output int n_both,
                             output int n_pre, output int n_sr);
    n_csr = 0; n_lo = 0; n_both = 0; n_pre = 0; n_sr = 0;
    for (int i = 0; i < 3000 && !ref_busy; i++) @(negedge clk);
    while (ref_busy) begin
      if (ras_n && !cas_n) n_csr++;
      if (!ras_n) n_lo++;
      if (!ras_n && !cas_n) n_both++;
      if (ras_n && cas_n) n_pre++;
      if (sr_active) n_sr++;
      @(negedge clk);
    end
  endtask

  task automatic wait_ras_fall(output int waited);
    logic prev;
    prev = ras_n;
    waited = 0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      waited++;
      if (prev && !ras_n) return;
      prev = ras_n;
    end
  endtask

  task automatic drop_sr_after(input int k);
    for (int i = 0; i < 3000 && !sr_active; i++) @(negedge clk);
    repeat (k) @(negedge clk);
    sr_req = 1'b0;
  endtask

  task automatic wait_req_rise();
    for (int i = 0; i < 3000 && (ref_req || ref_busy); i++) @(negedge clk);
    for (int i = 0; i < 3000 && !ref_req; i++) @(negedge clk);
  endtask

  initial begin
    int a, b, c, d, e;
    int viol, n, w;
    logic prev;

    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!ref_req && !ref_busy, "R1", "req/busy in reset", int'(ref_req) + int'(ref_busy), 0);
    chk(ras_n && cas_n, "R1", "strobes high in reset", int'(ras_n) + int'(cas_n), 2);
    chk(!init_done && !ovf && !sr_active, "R1", "ready/ovf/sr in reset",
        int'(init_done) + int'(ovf) + int'(sr_active), 0);

    rst_n = 1'b1;
    viol = 0;
    repeat (PAUSE - 2) begin
      @(negedge clk);
      if (ref_req || ref_busy || !ras_n || !cas_n || init_done) viol++;
    end
    chk(viol == 0, "R1", "activity during pause", viol, 0);
    n = 0;
    while (!ref_req && n < 10) begin @(negedge clk); n++; end
    chk(n <= 3, "R1", "cycles until request after pause", n, 2);

    // R5, R6: strobe shape of the first wake-up cycle
    bus_gnt = 1'b1;
    busy_period(a, b, c, d, e);
    chk(a == TCSR, "R5", "CAS-before-RAS lead", a, TCSR);
    chk(b == TRAS, "R6", "RAS low length", b, TRAS);
    chk(c == TCHR, "R6", "CAS hold after RAS fall", c, TCHR);
    chk(d == TRP, "R6", "precharge length", d, TRP);

    // R2: wake-up burst length
    n = 1;
    while (!init_done && n < 20) begin
      busy_period(a, b, c, d, e);
      n++;
    end
    chk(n == WAKE, "R2", "wake-up cycles before ready", n, WAKE);
    chk(init_done == 1'b1, "R2", "ready after burst", int'(init_done), 1);

    // R3: refresh spacing with a free bus
    wait_ras_fall(w);
    wait_ras_fall(w);
    chk(w == INTV, "R3", "refresh spacing", w, INTV);
    wait_ras_fall(w);
    chk(w == INTV, "R3", "refresh spacing repeat", w, INTV);

    // R4, R10, R11: backlog table
    bus_gnt = 1'b0;
    foreach (VECS[k]) begin
      int novf, nfall, hold;
      wait_req_rise();
      hold = VECS[k].m * INTV + INTV / 2;
      novf = 0; viol = 0;
      prev = ras_n;
      repeat (hold) begin
        @(negedge clk);
        if (ovf) novf++;
        if (ref_busy || !ras_n || !cas_n) viol++;
      end
      chk(viol == 0, "R4", "strobes moved without grant", viol, 0);
      chk(novf == VECS[k].novf, "R10", "overflow pulses", novf, VECS[k].novf);
      chk(init_done == (VECS[k].novf == 0), "R10", "ready after hold",
          int'(init_done), int'(VECS[k].novf == 0));
      bus_gnt = 1'b1;
      nfall = 0;
      prev = ras_n;
      for (int i = 0; i < 2000; i++) begin
        @(negedge clk);
        if (prev && !ras_n) nfall++;
        prev = ras_n;
        if (!ref_req && !ref_busy) break;
      end
      chk(nfall == VECS[k].drain, "R11", "cycles drained", nfall, VECS[k].drain);
      chk(init_done == 1'b1, "R10", "ready after drain", int'(init_done), 1);
      bus_gnt = 1'b0;
    end

    // R7: pending refresh beats a retention request
    wait_req_rise();
    sr_req = 1'b1;
    bus_gnt = 1'b1;
    busy_period(a, b, c, d, e);
    chk(e == 0, "R7", "retention before pending refresh", e, 0);
    chk(b == TRAS, "R7", "first cycle is a plain refresh", b, TRAS);

    // R8, R9: retention with early withdrawal
    fork
      busy_period(a, b, c, d, e);
      drop_sr_after(3);
    join
    chk(a == TCSR, "R8", "retention entry CAS lead", a, TCSR);
    chk(b >= TRASS && b <= TRASS + 1, "R8", "minimum retention hold", b, TRASS);
    chk(e == b, "R8", "sr_active spans the hold", e, b);
    chk(d == TRPS, "R9", "exit recovery length", d, TRPS);

    // R8: retention held by request
    sr_req = 1'b1;
    fork
      busy_period(a, b, c, d, e);
      drop_sr_after(80);
    join
    chk(b >= 80 && b <= 82, "R8", "hold follows request", b, 81);
    chk(d == TRPS, "R9", "exit recovery length repeat", d, TRPS);
    @(negedge clk);
    chk(!ref_busy && ras_n && cas_n, "R4", "strobes released after exit",
        int'(ref_busy), 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule